// File: doc/BRIEF.md
# TLB Access Permission Checker

This block translates one virtual address per request through a small fully associative translation buffer and decides whether the access is allowed. Each request carries an address, an access type, a user/kernel flag and the current process ID. Configuration inputs control three things: whether translation is on at all, which address segments bypass the buffer, and which protection checks are armed. The block returns either a translated physical address, a miss, or a fault with a vector number built from a configurable base.

Protection checks run in a fixed order, and only the first one that fails sets the vector. Software or a refill engine loads entries through a single write port that overwrites one entry by index. Page-table walking and exception handling stay outside the block.

Top module: `tlb_perm_check`

## Requirements
- R1: Translation is on when `cfg_glob[2]` or `cfg_glob[3]` is 1. When both are 0, the block reports a hit and `rsp_paddr` equals the request address.
- R2: With translation on, if `cfg_seg[seg]` is 1, where seg is `req_vaddr[31:28]`, the access bypasses the buffer. It reports a hit with `rsp_paddr` equal to the request address, whatever the entries hold.
- R3: Pages are 8 KB. An entry matches when its page number equals `req_vaddr[31:13]`. On a hit, `rsp_paddr` is `{ppn, req_vaddr[12:0]}`. When several entries match, the lowest index wins.
- R4: When no entry matches, the block reports a miss with vector `vec_base + 0`.
- R5: A matched entry whose global bit is 0 and whose PID differs from `req_pid[7:0]` gives a fault with vector `vec_base + 0`. The upper PID bits are ignored.
- R6: If `cfg_en_kern` is 1, the entry's kernel bit is 1 and `req_user` is 1, the block reports a fault with vector `vec_base + 2`.
- R7: A data write (`req_acc` = 1) with `cfg_en_wr` = 1 and the entry's write bit = 0 gives a fault with vector `vec_base + 3`. Access type 0 is a data read, and type 3 behaves as a read.
- R8: An instruction fetch (`req_acc` = 2) with `cfg_en_exec` = 1 and the entry's execute bit = 0 gives a fault with vector `vec_base + 3`.
- R9: If `cfg_en_valid` is 1 and the entry's valid bit is 0, the block reports a fault with vector `vec_base + 1`.
- R10: The checks apply in the order PID, kernel, write, execute, valid. Only the first failing check sets the vector. If a check is disabled, the next one is evaluated.
- R11: Results appear one cycle after `req_valid`, with a one-cycle `rsp_valid` pulse. Exactly one of hit, miss or fault is set. On a miss or fault, `rsp_paddr` and `rsp_vec` behave as follows: on a miss or fault, `rsp_paddr` is 0; on a hit, `rsp_vec` is 0. All result outputs hold their values while no request arrives.
- R12: When `wr_en` is 1, entry `wr_idx` is overwritten at the clock edge. A request in that same cycle still sees the old contents.
- R13: Reset clears every result output and every entry field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user mode |
| req_pid | input | 16 | Current process ID (low 8 bits compared) |
| cfg_glob | input | 4 | Global config; bits 3:2 enable translation |
| cfg_seg | input | 16 | Per-segment bypass bits |
| cfg_en_kern | input | 1 | Arm kernel-only check |
| cfg_en_wr | input | 1 | Arm write check |
| cfg_en_exec | input | 1 | Arm execute check |
| cfg_en_valid | input | 1 | Arm valid check |
| vec_base | input | 8 | Fault vector base |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 19 | Virtual page number |
| wr_ppn | input | 19 | Physical page number |
| wr_pid | input | 8 | Entry PID |
| wr_g | input | 1 | Global bit |
| wr_k | input | 1 | Kernel-only bit |
| wr_w | input | 1 | Write-allowed bit |
| wr_x | input | 1 | Execute-allowed bit |
| wr_v | input | 1 | Valid bit |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_vec | output | 8 | Miss or fault vector |
| rsp_paddr | output | 32 | Physical address |

## Verification
A corrupted entry field shows up on the very next lookup of that page. A wrong page number appears as a miss or as a wrong upper address. A wrong permission bit appears as a fault vector that is off by one step in the priority chain. A broken match or priority selection is visible one cycle after the request, in `rsp_vec` or `rsp_paddr`. That is why the stimulus uses entries that fail several checks at once, and why it switches checks off one by one. A stale or early write shows up on the request issued in the same cycle as the write.

// File: rtl/tlb_perm_check.sv
module tlb_perm_check #(
  parameter int VA_W    = 32,
  parameter int PG_W    = 13,
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int PIDIN_W = 16,
  parameter int VEC_W   = 8,
  parameter int SEG_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              req_vaddr,
  input  logic [1:0]                   req_acc,
  input  logic                         req_user,
  input  logic [PIDIN_W-1:0]           req_pid,
  input  logic [3:0]                   cfg_glob,
  input  logic [(1<<SEG_W)-1:0]        cfg_seg,
  input  logic                         cfg_en_kern,
  input  logic                         cfg_en_wr,
  input  logic                         cfg_en_exec,
  input  logic                         cfg_en_valid,
  input  logic [VEC_W-1:0]             vec_base,
  input  logic                         wr_en,
  input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
  input  logic [VA_W-PG_W-1:0]         wr_vpn,
  input  logic [VA_W-PG_W-1:0]         wr_ppn,
  input  logic [PID_W-1:0]             wr_pid,
  input  logic                         wr_g,
  input  logic                         wr_k,
  input  logic                         wr_w,
  input  logic                         wr_x,
  input  logic                         wr_v,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_miss,
  output logic                         rsp_fault,
  output logic [VEC_W-1:0]             rsp_vec,
  output logic [VA_W-1:0]              rsp_paddr
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0] e_vpn [ENTRIES];
  logic [VPN_W-1:0] e_ppn [ENTRIES];
  logic [PID_W-1:0] e_pid [ENTRIES];
  logic [ENTRIES-1:0] e_g, e_k, e_w, e_x, e_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
        e_pid[i] <= '0;
      end
      e_g <= '0; e_k <= '0; e_w <= '0; e_x <= '0; e_v <= '0;
    end else if (wr_en) begin
      e_vpn[wr_idx] <= wr_vpn;
      e_ppn[wr_idx] <= wr_ppn;
      e_pid[wr_idx] <= wr_pid;
      e_g[wr_idx]   <= wr_g;
      e_k[wr_idx]   <= wr_k;
      e_w[wr_idx]   <= wr_w;
      e_x[wr_idx]   <= wr_x;
      e_v[wr_idx]   <= wr_v;
    end
  end

  wire [VPN_W-1:0] vpn    = req_vaddr[VA_W-1:PG_W];
  wire [SEG_W-1:0] seg    = req_vaddr[VA_W-1 -: SEG_W];
  wire             mmu_on = cfg_glob[2] | cfg_glob[3];
  wire             bypass = !mmu_on || cfg_seg[seg];

  logic             found;
  logic [IDX_W-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (e_vpn[i] == vpn) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
  end

  logic             n_hit, n_miss, n_fault;
  logic [VEC_W-1:0] n_vec;
  logic [VA_W-1:0]  n_pa;
  always_comb begin
    n_hit = 1'b0; n_miss = 1'b0; n_fault = 1'b0;
    n_vec = '0;   n_pa = '0;
    if (bypass) begin
      n_hit = 1'b1;
      n_pa  = req_vaddr;
    end else if (!found) begin
      n_miss = 1'b1;
      n_vec  = vec_base;
    end else if (!e_g[sel] && e_pid[sel] != req_pid[PID_W-1:0]) begin
      n_fault = 1'b1;
      n_vec   = vec_base;
    end else if (cfg_en_kern && e_k[sel] && req_user) begin
      n_fault = 1'b1;
      n_vec   = vec_base + VEC_W'(2);
    end else if (req_acc == 2'd1 && cfg_en_wr && !e_w[sel]) begin
      n_fault = 1'b1;
      n_vec   = vec_base + VEC_W'(3);
    end else if (req_acc == 2'd2 && cfg_en_exec && !e_x[sel]) begin
      n_fault = 1'b1;
      n_vec   = vec_base + VEC_W'(3);
    end else if (cfg_en_valid && !e_v[sel]) begin
      n_fault = 1'b1;
      n_vec   = vec_base + VEC_W'(1);
    end else begin
      n_hit = 1'b1;
      n_pa  = {e_ppn[sel], req_vaddr[PG_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= n_hit;
        rsp_miss  <= n_miss;
        rsp_fault <= n_fault;
        rsp_vec   <= n_vec;
        rsp_paddr <= n_pa;
      end
    end
  end

  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_paddr) && $stable(rsp_vec) && $stable(rsp_hit));
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_glob[3:2] == 2'b00 |=> rsp_hit && rsp_paddr == $past(req_vaddr));
  assert_seg_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_seg[req_vaddr[VA_W-1 -: SEG_W]] |=> rsp_hit && rsp_paddr == $past(req_vaddr));
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_paddr[PG_W-1:0] == $past(req_vaddr[PG_W-1:0]));
  assert_miss_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_vec == $past(vec_base) && rsp_paddr == '0);
endmodule

// File: tb/tlb_perm_check_tb.sv
`timescale 1ns/1ps
module tlb_perm_check_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [15:0] req_pid = '0;
  logic [3:0]  cfg_glob = 4'b0100;
  logic [15:0] cfg_seg = '0;
  logic        cfg_en_kern = 1, cfg_en_wr = 1, cfg_en_exec = 1, cfg_en_valid = 0;
  logic [7:0]  vec_base = 8'h20;
  logic        wr_en = 0, wr_g = 0, wr_k = 0, wr_w = 0, wr_x = 0, wr_v = 0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0, wr_ppn = '0;
  logic [7:0]  wr_pid = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [7:0]  rsp_vec;
  logic [31:0] rsp_paddr;

  tlb_perm_check u_dut (.*);

  typedef struct {
    logic        hit, miss, fault;
    logic [7:0]  vec;
    logic [31:0] pa;
    string       tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  task automatic issue(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                       input logic [15:0] pid, input logic h, input logic m, input logic f,
                       input logic [7:0] v, input logic [31:0] pa, input string tag);
    exp_t e;
    req_vaddr = va; req_acc = acc; req_user = usr; req_pid = pid; req_valid = 1'b1;
    e.hit = h; e.miss = m; e.fault = f; e.vec = v; e.pa = pa; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_entry(input logic [3:0] idx, input logic [18:0] vpn, input logic [18:0] ppn,
                          input logic [7:0] pid, input logic [4:0] gkwxv);
    wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn; wr_pid = pid;
    {wr_g, wr_k, wr_w, wr_x, wr_v} = gkwxv;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R11: rsp_valid without request (actual 1 expected 0)");
        end else begin
          exp_t e;
          e = q.pop_front();
          if ({rsp_hit, rsp_miss, rsp_fault} !== {e.hit, e.miss, e.fault} ||
              rsp_vec !== e.vec || rsp_paddr !== e.pa) begin
            fails++;
            $display("FAIL %s: hit/miss/fault=%b%b%b vec=%h pa=%h expected %b%b%b vec=%h pa=%h",
                     e.tag, rsp_hit, rsp_miss, rsp_fault, rsp_vec, rsp_paddr,
                     e.hit, e.miss, e.fault, e.vec, e.pa);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_vec, rsp_paddr} !== '0) begin
      fails++;
      $display("FAIL R13: outputs in reset %b%b%b%b %h %h expected all zero",
               rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_vec, rsp_paddr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R13: cleared entries all hold page 0, PID 0, no flags
    cfg_en_kern = 0; cfg_en_wr = 0; cfg_en_exec = 0;
    issue(32'h0000_0123, 2'd0, 1'b0, 16'h0000, 1, 0, 0, 8'h00, 32'h0000_0123, "R13");
    cfg_en_valid = 1;
    issue(32'h0000_0123, 2'd0, 1'b0, 16'h0000, 0, 0, 1, 8'h21, 32'h0, "R13");
    cfg_en_kern = 1; cfg_en_wr = 1; cfg_en_exec = 1; cfg_en_valid = 0;

    wr_entry(4'd1, 19'h00001, 19'h40001, 8'h05, 5'b00111);
    wr_entry(4'd2, 19'h00002, 19'h40002, 8'h07, 5'b11000);
    wr_entry(4'd3, 19'h00003, 19'h7ABCD, 8'h05, 5'b01000);
    wr_entry(4'd4, 19'h00009, 19'h11111, 8'h00, 5'b10111);
    wr_entry(4'd5, 19'h00009, 19'h22222, 8'h00, 5'b10111);

    cfg_glob = 4'b0000;
    issue(32'h0000_4123, 2'd1, 1'b1, 16'h0000, 1, 0, 0, 8'h00, 32'h0000_4123, "R1");
    cfg_glob = 4'b1000;
    issue(32'h0000_2123, 2'd0, 1'b0, 16'h0005, 1, 0, 0, 8'h00, 32'h8000_2123, "R1");
    issue(32'h0001_3FFF, 2'd2, 1'b1, 16'h0033, 1, 0, 0, 8'h00, 32'h2222_3FFF, "R3");
    cfg_glob = 4'b0100;
    cfg_seg = 16'h0100;
    issue(32'h8000_2004, 2'd1, 1'b1, 16'h0000, 1, 0, 0, 8'h00, 32'h8000_2004, "R2");
    cfg_seg = 16'h0001;
    issue(32'h0000_4000, 2'd1, 1'b1, 16'h0000, 1, 0, 0, 8'h00, 32'h0000_4000, "R2");
    cfg_seg = 16'h0000;
    issue(32'h000F_0000, 2'd0, 1'b0, 16'h0000, 0, 1, 0, 8'h20, 32'h0, "R4");
    issue(32'h0000_2010, 2'd0, 1'b0, 16'h0006, 0, 0, 1, 8'h20, 32'h0, "R5");
    issue(32'h0000_2010, 2'd0, 1'b0, 16'h1205, 1, 0, 0, 8'h00, 32'h8000_2010, "R5");
    issue(32'h0000_4008, 2'd0, 1'b1, 16'h0099, 0, 0, 1, 8'h22, 32'h0, "R6");
    issue(32'h0000_4008, 2'd0, 1'b0, 16'h0099, 1, 0, 0, 8'h00, 32'h8000_4008, "R7");
    issue(32'h0000_4008, 2'd3, 1'b0, 16'h0099, 1, 0, 0, 8'h00, 32'h8000_4008, "R7");
    issue(32'h0000_4008, 2'd1, 1'b0, 16'h0099, 0, 0, 1, 8'h23, 32'h0, "R7");
    issue(32'h0000_4008, 2'd2, 1'b0, 16'h0099, 0, 0, 1, 8'h23, 32'h0, "R8");
    cfg_en_kern = 0;
    issue(32'h0000_4008, 2'd0, 1'b1, 16'h0099, 1, 0, 0, 8'h00, 32'h8000_4008, "R6");
    cfg_en_kern = 1;
    cfg_en_valid = 1;
    issue(32'h0000_4008, 2'd0, 1'b0, 16'h0099, 0, 0, 1, 8'h21, 32'h0, "R9");
    cfg_en_exec = 0;
    issue(32'h0000_4008, 2'd2, 1'b0, 16'h0099, 0, 0, 1, 8'h21, 32'h0, "R8");
    cfg_en_exec = 1;
    issue(32'h0000_6000, 2'd1, 1'b1, 16'h0009, 0, 0, 1, 8'h20, 32'h0, "R10");
    issue(32'h0000_6000, 2'd1, 1'b1, 16'h0005, 0, 0, 1, 8'h22, 32'h0, "R10");
    cfg_en_kern = 0;
    issue(32'h0000_6000, 2'd1, 1'b1, 16'h0005, 0, 0, 1, 8'h23, 32'h0, "R10");
    cfg_en_wr = 0;
    issue(32'h0000_6000, 2'd1, 1'b1, 16'h0005, 0, 0, 1, 8'h21, 32'h0, "R10");
    cfg_en_valid = 0;
    issue(32'h0000_6ABC, 2'd1, 1'b1, 16'h0005, 1, 0, 0, 8'h00, 32'hF579_AABC, "R10");
    cfg_en_kern = 1; cfg_en_wr = 1;

    // R12: write and lookup of the same entry in one cycle
    wr_idx = 4'd1; wr_vpn = 19'h00001; wr_ppn = 19'h00055; wr_pid = 8'h05;
    {wr_g, wr_k, wr_w, wr_x, wr_v} = 5'b00111;
    wr_en = 1'b1;
    issue(32'h0000_2001, 2'd0, 1'b0, 16'h0005, 1, 0, 0, 8'h00, 32'h8000_2001, "R12");
    wr_en = 1'b0;
    issue(32'h0000_2001, 2'd0, 1'b0, 16'h0005, 1, 0, 0, 8'h00, 32'h000A_A001, "R12");

    // R11: idle cycles keep the last result and no strobe
    held = 32'h000A_A001;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== held || rsp_hit !== 1'b1) begin
      fails++;
      $display("FAIL R11: idle valid=%b pa=%h hit=%b expected 0 %h 1",
               rsp_valid, rsp_paddr, rsp_hit, held);
    end
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d results missing expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule